// File: doc/BRIEF.md
# Two-Stage Masking Filter Combiner

This block is a reconfigurable sharp-transition lowpass channel filter. It is built as two cascaded masking stages around one interpolated band-edge prototype. The first stage runs the prototype with its taps spread by the product L1·L2 and forms the prototype's complement from a centre-tap delay. It masks both branches with a pair of short filters whose taps are spread by L2, and adds the two branch results. That sum then takes the role of the band-edge filter for a second stage. The second stage forms its own complement from a delayed copy of the input. It masks the first-stage result and this complement with a unit-spaced pair, and adds them to give the output.

The channel width changes only through the two interpolation factors, which are loaded through a small configuration port. The arithmetic and the coefficients stay the same for every width. Setting L2 to 1 selects a single-stage filter, and the first-stage sum is then sent to the output. A controller with three states handles every configuration change. FLUSH is entered from reset or on any load; it clears all history and moves to FILL on the next cycle. FILL counts accepted samples and moves to RUN once the history span is covered. RUN passes every accepted sample, and any load returns it to FLUSH.

Top module: `frm_two_stage_combiner`

## Requirements
- R1: With L2 ≥ 2, out = rs(Σ p2[k]·y1[n−k] + q2[k]·c2[n−k]), k = 0..2. Here rs(v) means floor((v + 8192) / 16384) saturated to signed 16 bits. The default coefficients are p2 = {2048, 12288, 2048} and q2 = {−4096, 16384, 4096}.
- R2: The band-edge branch is a[n] = rs(Σ h[k]·x[n − k·L]) for k = 0..4, with L = L1·L2 and h = {1024, 4096, 6144, 4096, 1024}. Its complement is c[n] = x[n − 2L] − a[n].
- R3: The first-stage sum is y1[n] = rs(Σ p1[k]·a[n − k·L2] + q1[k]·c[n − k·L2]) for k = 0..2. The defaults are p1 = {4096, 8192, 4096} and q1 = {8192, 8192, 0}, where the last q1 tap is zero padding that keeps both branches the same length.
- R4: The second-stage complement is c2[n] = x[n − L2·(2·L1 + 1)] − y1[n]. The second masking pair uses unit tap spacing.
- R5: With L2 = 1, the second pair is bypassed and out = y1.
- R6: Complement values keep one extra bit (17 bits signed). Every filter sum is rounded half-up and saturated to 16 bits, so that a full-scale input never wraps.
- R7: A cfg_load pulse captures L1 and L2, each clamped to the range 1..4 (a value of 0 becomes 1). It clears all history. Samples offered in the load cycle or the flush cycle that follows are dropped.
- R8: After a flush, the first S accepted samples produce no out_valid. Here S = max(4L, L2·(2L1+1)) + 2·L2 + (2 if L2 ≥ 2, else 0). Every later accepted sample produces exactly one out_valid, in order, with history before the flush read as zero.
- R9: After reset, out_valid is low and the factors are L1 = L2 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-cycle pulse that loads new factors |
| cfg_l1 | input | 3 | First-stage interpolation factor |
| cfg_l2 | input | 3 | Second-stage interpolation factor |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed filtered sample |

## Verification
The bench targets the tap spacings at the largest product L1·L2 = 16. A design that spaced the masking taps by L instead of L2, or used the wrong complement delay, would produce a different impulse response there. The bench also counts how many outputs are suppressed after each reload, for several factor pairs. A wrong fill span either lets history samples from before the flush leak out or drops good samples. Further cases are full-scale inputs, where missing saturation wraps the sign, and a load with out-of-range factors while samples keep arriving. Clamping done wrong gives an out-of-range tap read, and a failure to drop those samples shifts the whole response by one or two samples.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef logic [15:0] idx_t;

    typedef enum logic [1:0] {
        S_FLUSH = 2'd0,
        S_FILL  = 2'd1,
        S_RUN   = 2'd2
    } fsm_t;

    // round half-up by 2^fb, then clamp to a signed w-bit range
    function automatic logic signed [63:0] rnd_sat(input logic signed [63:0] acc,
                                                   input int fb, input int w);
        logic signed [63:0] r;
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        r  = (acc + (64'sd1 <<< (fb - 1))) >>> fb;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (r > hi)      r = hi;
        else if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/frm_tapline.sv
module frm_tapline #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] past [DEPTH]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) past[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) past[i] <= '0;
        end else if (en) begin
            past[0] <= din;
            for (int i = 1; i < DEPTH; i++) past[i] <= past[i-1];
        end
    end

    // R7
    tap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (past[0] == '0));

endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl
    import frm_pkg::*;
#(
    parameter int N     = 5,
    parameter int M     = 3,
    parameter int L1MAX = 4,
    parameter int L2MAX = 4,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [LW-1:0] cfg_l1,
    input  logic [LW-1:0] cfg_l2,
    input  logic          in_valid,
    output logic          flush,
    output logic          accept,
    output logic          pass,
    output logic          single,
    output idx_t          l_tot,
    output idx_t          l2_o,
    output idx_t          cdel1,
    output idx_t          xdel2
);

    localparam idx_t HALF_N = idx_t'((N - 1) / 2);
    localparam idx_t HALF_M = idx_t'((M - 1) / 2);
    localparam idx_t NM1    = idx_t'(N - 1);
    localparam idx_t MM1    = idx_t'(M - 1);
    localparam idx_t L1TOP  = idx_t'(L1MAX);
    localparam idx_t L2TOP  = idx_t'(L2MAX);

    fsm_t state_q, state_d;
    idx_t l1_q, l2_q, l1_in, l2_in;
    idx_t cnt_q, cnt_d;
    idx_t span, base_a;

    // clamp requested factors into 1..MAX
    always_comb begin
        l1_in = idx_t'(cfg_l1);
        l2_in = idx_t'(cfg_l2);
        if (l1_in == '0)        l1_in = idx_t'(1);
        else if (l1_in > L1TOP) l1_in = L1TOP;
        if (l2_in == '0)        l2_in = idx_t'(1);
        else if (l2_in > L2TOP) l2_in = L2TOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_q <= idx_t'(1);
            l2_q <= idx_t'(1);
        end else if (cfg_load) begin
            l1_q <= l1_in;
            l2_q <= l2_in;
        end
    end

    // derived delays and fill span
    always_comb begin
        l_tot  = l1_q * l2_q;
        l2_o   = l2_q;
        cdel1  = l_tot * HALF_N;
        xdel2  = l2_q * (l1_q * HALF_N + HALF_M);
        single = (l2_q == idx_t'(1));
        base_a = l_tot * NM1;
        span   = ((base_a > xdel2) ? base_a : xdel2) + l2_q * MM1 + (single ? '0 : MM1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FLUSH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_FLUSH: begin
                state_d = S_FILL;
                cnt_d   = '0;
            end
            S_FILL: begin
                if (accept) begin
                    cnt_d = cnt_q + idx_t'(1);
                    if (cnt_q + idx_t'(1) >= span) state_d = S_RUN;
                end
            end
            S_RUN: begin
                state_d = S_RUN;
            end
            default: begin
                state_d = S_FLUSH;
            end
        endcase
        if (cfg_load) state_d = S_FLUSH;
    end

    // outputs
    always_comb begin
        flush  = (state_q == S_FLUSH);
        accept = in_valid && !flush && !cfg_load;
        pass   = accept && (state_q == S_RUN);
    end

    // R7
    load_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (state_q == S_FLUSH));

    // R7
    l_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_q >= idx_t'(1)) && (l1_q <= L1TOP) && (l2_q >= idx_t'(1)) && (l2_q <= L2TOP));

    // R8
    flush_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH && !cfg_load) |=> (state_q == S_FILL && cnt_q == '0));

endmodule

// File: rtl/frm_edge_stage.sv
module frm_edge_stage
    import frm_pkg::*;
#(
    parameter int W     = 16,
    parameter int CW    = 16,
    parameter int FB    = 14,
    parameter int N     = 5,
    parameter int M     = 3,
    parameter int L1MAX = 4,
    parameter int L2MAX = 4,
    parameter logic [N*CW-1:0] COEF = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    input  idx_t                l_tot,
    input  idx_t                cdel1,
    input  idx_t                xdel2,
    output logic                v_q,
    output logic signed [W-1:0] a_q,
    output logic signed [W:0]   c_q,
    output logic signed [W-1:0] xd_q
);

    localparam int SPAN_A = L1MAX * L2MAX * (N - 1);
    localparam int SPAN_X = L2MAX * (L1MAX * ((N - 1) / 2) + (M - 1) / 2);
    localparam int DEPTH  = (SPAN_A > SPAN_X) ? SPAN_A : SPAN_X;

    logic signed [W-1:0] past [DEPTH];
    logic signed [63:0]  acc, cf, tv, r;
    logic signed [W-1:0] a_n, xd1, xd2, tap;
    logic signed [W:0]   c_n;
    idx_t                j;

    frm_tapline #(.W(W), .DEPTH(DEPTH)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (in_valid),
        .din  (in_data),
        .past (past)
    );

    always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
            j   = idx_t'(k) * l_tot;
            tap = (j == '0) ? in_data : past[j - idx_t'(1)];
            cf  = {{(64-CW){COEF[k*CW+CW-1]}}, COEF[k*CW +: CW]};
            tv  = {{(64-W){tap[W-1]}}, tap};
            acc = acc + cf * tv;
        end
        r   = rnd_sat(acc, FB, W);
        a_n = r[W-1:0];
        xd1 = (cdel1 == '0) ? in_data : past[cdel1 - idx_t'(1)];
        xd2 = (xdel2 == '0) ? in_data : past[xdel2 - idx_t'(1)];
        c_n = {xd1[W-1], xd1} - {a_n[W-1], a_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q  <= 1'b0;
            a_q  <= '0;
            c_q  <= '0;
            xd_q <= '0;
        end else if (clr) begin
            v_q  <= 1'b0;
            a_q  <= '0;
            c_q  <= '0;
            xd_q <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                a_q  <= a_n;
                c_q  <= c_n;
                xd_q <= xd2;
            end
        end
    end

    // R8
    edge_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> v_q);

endmodule

// File: rtl/frm_mask_pair.sv
module frm_mask_pair
    import frm_pkg::*;
#(
    parameter int W     = 16,
    parameter int CW    = 16,
    parameter int FB    = 14,
    parameter int M     = 3,
    parameter int SPMAX = 4,
    parameter logic [M*CW-1:0] COEF_P = '0,
    parameter logic [M*CW-1:0] COEF_Q = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_valid,
    input  logic signed [W-1:0] p_in,
    input  logic signed [W:0]   q_in,
    input  idx_t                sp,
    output logic                y_valid,
    output logic signed [W-1:0] y_q
);

    localparam int DEPTH = (M - 1) * SPMAX;

    logic signed [W-1:0] p_past [DEPTH];
    logic signed [W:0]   q_past [DEPTH];
    logic signed [63:0]  acc, cp, cq, tp, tq, r;
    logic signed [W-1:0] pv;
    logic signed [W:0]   qv;
    idx_t                j;

    frm_tapline #(.W(W), .DEPTH(DEPTH)) u_pline (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(in_valid), .din(p_in), .past(p_past)
    );

    frm_tapline #(.W(W+1), .DEPTH(DEPTH)) u_qline (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(in_valid), .din(q_in), .past(q_past)
    );

    always_comb begin
        acc = '0;
        for (int k = 0; k < M; k++) begin
            j   = idx_t'(k) * sp;
            pv  = (j == '0) ? p_in : p_past[j - idx_t'(1)];
            qv  = (j == '0) ? q_in : q_past[j - idx_t'(1)];
            cp  = {{(64-CW){COEF_P[k*CW+CW-1]}}, COEF_P[k*CW +: CW]};
            cq  = {{(64-CW){COEF_Q[k*CW+CW-1]}}, COEF_Q[k*CW +: CW]};
            tp  = {{(64-W){pv[W-1]}}, pv};
            tq  = {{(63-W){qv[W]}}, qv};
            acc = acc + cp * tp + cq * tq;
        end
        r = rnd_sat(acc, FB, W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_valid <= 1'b0;
            y_q     <= '0;
        end else if (clr) begin
            y_valid <= 1'b0;
            y_q     <= '0;
        end else begin
            y_valid <= in_valid;
            if (in_valid) y_q <= r[W-1:0];
        end
    end

    // R8
    pair_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> y_valid);

endmodule

// File: rtl/frm_two_stage_combiner.sv
module frm_two_stage_combiner
    import frm_pkg::*;
#(
    parameter int W     = 16,
    parameter int CW    = 16,
    parameter int FB    = 14,
    parameter int N     = 5,
    parameter int M     = 3,
    parameter int L1MAX = 4,
    parameter int L2MAX = 4,
    parameter int LW    = $clog2(((L1MAX > L2MAX) ? L1MAX : L2MAX) + 1),
    parameter logic [N*CW-1:0] EDGE_COEF = {16'd1024, 16'd4096, 16'd6144, 16'd4096, 16'd1024},
    parameter logic [M*CW-1:0] P1_COEF   = {16'd4096, 16'd8192, 16'd4096},
    parameter logic [M*CW-1:0] Q1_COEF   = {16'd0, 16'd8192, 16'd8192},
    parameter logic [M*CW-1:0] P2_COEF   = {16'd2048, 16'd12288, 16'd2048},
    parameter logic [M*CW-1:0] Q2_COEF   = {16'd4096, 16'd16384, 16'hF000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [LW-1:0] cfg_l1,
    input  logic [LW-1:0] cfg_l2,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    output logic          out_valid,
    output logic [W-1:0]  out_data
);

    logic flush, accept, pass, single;
    idx_t l_tot, l2, cdel1, xdel2;

    logic                ea_v, m1_v, m2_v;
    logic signed [W-1:0] ea_a, ea_xd, y1, y2;
    logic signed [W:0]   ea_c, c2;
    logic signed [W-1:0] xd_b, y1_c;
    logic                pass_a, pass_b, pass_c;

    frm_ctrl #(.N(N), .M(M), .L1MAX(L1MAX), .L2MAX(L2MAX), .LW(LW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_load(cfg_load),
        .cfg_l1  (cfg_l1),
        .cfg_l2  (cfg_l2),
        .in_valid(in_valid),
        .flush   (flush),
        .accept  (accept),
        .pass    (pass),
        .single  (single),
        .l_tot   (l_tot),
        .l2_o    (l2),
        .cdel1   (cdel1),
        .xdel2   (xdel2)
    );

    frm_edge_stage #(.W(W), .CW(CW), .FB(FB), .N(N), .M(M),
                     .L1MAX(L1MAX), .L2MAX(L2MAX), .COEF(EDGE_COEF)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .in_valid(accept),
        .in_data (in_data),
        .l_tot   (l_tot),
        .cdel1   (cdel1),
        .xdel2   (xdel2),
        .v_q     (ea_v),
        .a_q     (ea_a),
        .c_q     (ea_c),
        .xd_q    (ea_xd)
    );

    frm_mask_pair #(.W(W), .CW(CW), .FB(FB), .M(M), .SPMAX(L2MAX),
                    .COEF_P(P1_COEF), .COEF_Q(Q1_COEF)) u_mask1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .in_valid(ea_v),
        .p_in    (ea_a),
        .q_in    (ea_c),
        .sp      (l2),
        .y_valid (m1_v),
        .y_q     (y1)
    );

    // second-stage complement from the aligned delayed input
    assign c2 = {xd_b[W-1], xd_b} - {y1[W-1], y1};

    frm_mask_pair #(.W(W), .CW(CW), .FB(FB), .M(M), .SPMAX(1),
                    .COEF_P(P2_COEF), .COEF_Q(Q2_COEF)) u_mask2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .in_valid(m1_v),
        .p_in    (y1),
        .q_in    (c2),
        .sp      (idx_t'(1)),
        .y_valid (m2_v),
        .y_q     (y2)
    );

    // side pipeline: pass flag and delayed input follow the samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_a <= 1'b0; pass_b <= 1'b0; pass_c <= 1'b0;
            xd_b   <= '0;   y1_c   <= '0;
            out_valid <= 1'b0; out_data <= '0;
        end else if (flush) begin
            pass_a <= 1'b0; pass_b <= 1'b0; pass_c <= 1'b0;
            xd_b   <= '0;   y1_c   <= '0;
            out_valid <= 1'b0; out_data <= '0;
        end else begin
            if (accept) pass_a <= pass;
            if (ea_v) begin
                pass_b <= pass_a;
                xd_b   <= ea_xd;
            end
            if (m1_v) begin
                pass_c <= pass_b;
                y1_c   <= y1;
            end
            out_valid <= m2_v && pass_c;
            if (m2_v) out_data <= single ? y1_c : y2;
        end
    end

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R8
    out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(m2_v));

endmodule

// File: tb/sim_frm_two_stage_combiner.sv
`timescale 1ns/1ps
module sim_frm_two_stage_combiner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [2:0]  cfg_l1 = 3'd1;
    logic [2:0]  cfg_l2 = 3'd1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    always #2.5 clk = ~clk;

    frm_two_stage_combiner u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_l1(cfg_l1), .cfg_l2(cfg_l2),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int rx_seg = 0;
    int exp_q[$];
    string tag_q[$];

    // reference model state
    int ml1 = 1, ml2 = 1, span = 6, seg_n = 0;
    longint mx[1024], mav[1024], mcv[1024], my1[1024], mc2[1024];
    longint h[5]  = '{1024, 4096, 6144, 4096, 1024};
    longint p1[3] = '{4096, 8192, 4096};
    longint q1[3] = '{8192, 8192, 0};
    longint p2[3] = '{2048, 12288, 2048};
    longint q2[3] = '{-4096, 16384, 4096};

    function automatic longint rs(longint v);
        longint r;
        r = (v + 8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic longint gx(int i);  return (i < 0) ? 0 : mx[i];  endfunction
    function automatic longint ga(int i);  return (i < 0) ? 0 : mav[i]; endfunction
    function automatic longint gc(int i);  return (i < 0) ? 0 : mcv[i]; endfunction
    function automatic longint gy(int i);  return (i < 0) ? 0 : my1[i]; endfunction
    function automatic longint gc2(int i); return (i < 0) ? 0 : mc2[i]; endfunction

    task automatic check(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            rx_seg++;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8: actual unexpected output %0d expected none", $signed(out_data));
            end else begin
                check(tag_q.pop_front(), longint'($signed(out_data)), longint'(exp_q.pop_front()));
            end
        end
    end

    // driver: computes the model for the next sample, then offers it
    task automatic send(int x, string tag, int gap);
        int n, L, lm;
        longint acc;
        n = seg_n; L = ml1 * ml2;
        mx[n] = x;
        acc = 0;
        for (int k = 0; k < 5; k++) acc += h[k] * gx(n - k * L);
        mav[n] = rs(acc);
        mcv[n] = gx(n - 2 * L) - mav[n];                     // R2 complement
        acc = 0;
        for (int k = 0; k < 3; k++) acc += p1[k] * ga(n - k * ml2) + q1[k] * gc(n - k * ml2);
        my1[n] = rs(acc);                                    // R3
        mc2[n] = gx(n - ml2 * (2 * ml1 + 1)) - my1[n];       // R4
        acc = 0;
        for (int k = 0; k < 3; k++) acc += p2[k] * gy(n - k) + q2[k] * gc2(n - k);
        lm = int'((ml2 == 1) ? my1[n] : rs(acc));            // R1 / R5
        if (n >= span) begin
            exp_q.push_back(lm);
            tag_q.push_back(tag);
        end
        seg_n++;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x[15:0];
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // close the segment, then reload with junk samples in the load and flush cycles
    task automatic reconfig(int l1, int l2);
        idle(12);
        check("R8 fill count", rx_seg, (seg_n > span) ? seg_n - span : 0);
        rx_seg = 0;
        @(negedge clk);
        cfg_load = 1'b1; cfg_l1 = l1[2:0]; cfg_l2 = l2[2:0];
        in_valid = 1'b1; in_data = 16'h3039;
        @(negedge clk);
        cfg_load = 1'b0; in_valid = 1'b1; in_data = 16'h7000;
        ml1 = (l1 < 1) ? 1 : (l1 > 4) ? 4 : l1;
        ml2 = (l2 < 1) ? 1 : (l2 > 4) ? 4 : l2;
        span = ((4 * ml1 * ml2 > ml2 * (2 * ml1 + 1)) ? 4 * ml1 * ml2 : ml2 * (2 * ml1 + 1))
               + 2 * ml2 + ((ml2 == 1) ? 0 : 2);
        seg_n = 0;
    endtask

    task automatic impulse(string tag, int amp, int tail);
        for (int i = 0; i < span; i++) send(0, tag, 0);
        send(amp, tag, 0);
        for (int i = 0; i < tail; i++) send(0, tag, 0);
    endtask

    task automatic noise(string tag, int count, int amp);
        for (int i = 0; i < count; i++)
            send($urandom_range(2 * amp) - amp, tag, $urandom_range(2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R9 reset out_valid", out_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 idle out_valid", out_valid, 0);
        // R9 / R5: default factors give the single-stage path
        impulse("R5 default", 8192, 20);
        noise("R9 default", 30, 12000);
        // R1 two-stage impulse and random data
        reconfig(2, 2);
        impulse("R1 L1=2 L2=2", 8192, 60);
        noise("R3 L1=2 L2=2", 60, 20000);
        // R2 largest interpolation
        reconfig(4, 4);
        impulse("R2 L1=4 L2=4", 12000, 110);
        // R5 single stage with L1 > 1
        reconfig(3, 1);
        noise("R5 L1=3 L2=1", 50, 20000);
        impulse("R5 L1=3 impulse", 8192, 20);
        // R4 second-stage complement delay with L1 = 1
        reconfig(1, 3);
        impulse("R4 L1=1 L2=3", 8192, 40);
        // R7 clamping: 0 -> 1, 7 -> 4
        reconfig(0, 7);
        impulse("R7 clamp", 8192, 30);
        noise("R7 clamp noise", 40, 30000);
        // R6 full-scale drive
        reconfig(2, 3);
        for (int i = 0; i < 30; i++) send(32767, "R6 full scale", 0);
        for (int i = 0; i < 30; i++) send(((i % 2) == 0) ? 32767 : -32768, "R6 alternating", 0);
        for (int i = 0; i < 20; i++) send(-32768, "R6 negative", 0);
        idle(12);
        check("R8 fill count", rx_seg, (seg_n > span) ? seg_n - span : 0);
        check("R8 queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule